// File: doc/BRIEF.md
# SPI Data Path Skew Adjuster

This block sits between the serial pins and the shift register of an SPI master. It gives the outgoing data line a programmable delay in whole core cycles. It gives the incoming data line its own programmable delay. It also moves the point at which incoming data is captured: two cycles early, one cycle early, nominal, or one cycle late, all relative to the nominal sample strobe.

An early capture cannot take a strobe from the future. The block therefore gives the incoming data a fixed alignment latency of two cycles and delays the strobe by the capture code instead. The consumer samples `miso_o` whenever `cap_o` is high. A code of 2 keeps the strobe and the data in their nominal relation. Lower codes sample data that is relatively older (early capture), and code 3 samples data that is relatively newer (late capture).

In automatic mode the block picks the input delay and the capture offset itself, from the bus rate in MHz and the active clock divisor. It then leaves the output delay at zero. Settings, whether given by hand or picked automatically, are taken only on the cycle that starts a burst and are held until the next burst start.

Top module: `spi_io_skew`

## Requirements
- R1: While reset is active, all delay flops are cleared and the held settings become output delay 0, input delay 0 and capture code 2 (nominal).
- R2: `mosi_o` equals `mosi_i` delayed by the held output delay of 0 to 3 cycles; a delay of 0 passes `mosi_i` through in the same cycle.
- R3: `miso_o` equals `miso_i` delayed by the held input delay plus a fixed 2 cycles, which gives a total of 2 to 5 cycles.
- R4: `cap_o` equals `strobe_i` delayed by the held capture code in cycles. The codes are 0 (two cycles early), 1 (one early), 2 (nominal) and 3 (one late).
- R5: Settings are loaded on a clock edge where `burst_start_i` is high and take effect from the next cycle. While `burst_start_i` is low, changes on `auto_en_i`, `mo_dly_i`, `mi_dly_i`, `cap_off_i`, `rate_i` and `div_i` have no effect on the outputs.
- R6: With `auto_en_i` low at a burst start, the held settings are taken from `mo_dly_i`, `mi_dly_i` and `cap_off_i`.
- R7: With `auto_en_i` high at a burst start, the input delay is 0 whenever `rate_i` is 40 or more. The capture code is then chosen by rate: 3 for a rate of 100 or more, 2 for 80 to 99, and 1 for 40 to 79.
- R8: With `auto_en_i` high and `rate_i` below 40, the capture code is 0. The input delay is chosen by divisor: 3 when `div_i` is at least 16, 2 when it is 8 to 15, 1 when it is 6 or 7, and 0 below 6.
- R9: With `auto_en_i` high at a burst start, the held output delay is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | Loads the settings for the coming burst |
| auto_en_i | input | 1 | Selects automatic settings at burst start |
| mo_dly_i | input | 2 | Manual output delay in cycles |
| mi_dly_i | input | 2 | Manual input delay in cycles |
| cap_off_i | input | 2 | Manual capture code |
| rate_i | input | RATE_W | Bus rate in MHz, used in automatic mode |
| div_i | input | DIV_W | Active clock divisor, used in automatic mode |
| mosi_i | input | 1 | Raw outgoing data from the shift register |
| miso_i | input | 1 | Raw incoming data from the pin |
| strobe_i | input | 1 | Nominal sample strobe |
| mosi_o | output | 1 | Delayed outgoing data |
| miso_o | output | 1 | Delayed, aligned incoming data |
| cap_o | output | 1 | Adjusted capture strobe |

## Verification
The bench steps the rate across the automatic-mode boundaries 100/99, 80/79 and 40/39. It also steps the divisor across 16/15, 8/7 and 6/5. A comparison off by one at any of these edges would show up as the wrong tap on `miso_o` or `cap_o`. It changes the manual fields between burst starts, which catches a design that tracks its inputs instead of holding its settings. It also covers the zero-delay taps, where an extra flop on the pass-through path would shift the output by a cycle. The capture codes 0 and 3 are checked against the data latency: an encoding that is reversed or has an offset would move the strobe to the wrong bit.

// File: rtl/spi_skew_pkg.sv
package spi_skew_pkg;
  localparam int unsigned DLY_W     = 2;
  localparam int unsigned DLY_MAX   = (1 << DLY_W) - 1;
  localparam int unsigned MISO_BASE = 2;  // fixed alignment latency on the input path

  typedef enum logic [DLY_W-1:0] {
    CAP_EARLY2  = 2'd0,
    CAP_EARLY1  = 2'd1,
    CAP_NOMINAL = 2'd2,
    CAP_LATE1   = 2'd3
  } cap_off_e;

  typedef struct packed {
    logic [DLY_W-1:0] mo;
    logic [DLY_W-1:0] mi;
    cap_off_e         cap;
  } skew_cfg_t;
endpackage

// File: rtl/spi_skew_line.sv
module spi_skew_line #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned SEL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             q_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(DEPTH);

  logic [DEPTH:1] sr_q;
  logic [DEPTH:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q[1] <= d_i;
      for (int k = 2; k <= DEPTH; k++) sr_q[k] <= sr_q[k-1];
    end
  end

  assign tap = {sr_q, d_i};
  assign q_o = (sel_i > LAST) ? sr_q[DEPTH] : tap[sel_i];
endmodule

// File: rtl/spi_skew_auto.sv
module spi_skew_auto
  import spi_skew_pkg::*;
#(
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned RATE_HI  = 100,
  parameter int unsigned RATE_MID = 80,
  parameter int unsigned RATE_LO  = 40,
  parameter int unsigned DIV_3    = 16,
  parameter int unsigned DIV_2    = 8,
  parameter int unsigned DIV_1    = 6
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DIV_W-1:0]  div_i,
  output skew_cfg_t         cfg_o
);
  always_comb begin
    cfg_o = '{mo: '0, mi: '0, cap: CAP_EARLY2};
    if (rate_i >= RATE_W'(RATE_HI))       cfg_o.cap = CAP_LATE1;
    else if (rate_i >= RATE_W'(RATE_MID)) cfg_o.cap = CAP_NOMINAL;
    else if (rate_i >= RATE_W'(RATE_LO))  cfg_o.cap = CAP_EARLY1;
    else if (div_i >= DIV_W'(DIV_3))      cfg_o.mi  = 2'd3;
    else if (div_i >= DIV_W'(DIV_2))      cfg_o.mi  = 2'd2;
    else if (div_i >= DIV_W'(DIV_1))      cfg_o.mi  = 2'd1;
  end
endmodule

// File: rtl/spi_skew_cfg.sv
module spi_skew_cfg
  import spi_skew_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      burst_start_i,
  input  logic      auto_en_i,
  input  skew_cfg_t man_cfg_i,
  input  skew_cfg_t auto_cfg_i,
  output skew_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cfg_o <= '{mo: '0, mi: '0, cap: CAP_NOMINAL};
    else if (burst_start_i) cfg_o <= auto_en_i ? auto_cfg_i : man_cfg_i;
  end
endmodule

// File: rtl/spi_io_skew.sv
module spi_io_skew
  import spi_skew_pkg::*;
#(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_start_i,
  input  logic              auto_en_i,
  input  logic [1:0]        mo_dly_i,
  input  logic [1:0]        mi_dly_i,
  input  logic [1:0]        cap_off_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              mosi_i,
  input  logic              miso_i,
  input  logic              strobe_i,
  output logic              mosi_o,
  output logic              miso_o,
  output logic              cap_o
);
  localparam int unsigned MISO_DEPTH = DLY_MAX + MISO_BASE;
  localparam int unsigned MISO_SEL_W = $clog2(MISO_DEPTH + 1);

  skew_cfg_t man_cfg, auto_cfg, cfg_q;
  logic [MISO_SEL_W-1:0] miso_sel;

  assign man_cfg = '{mo: mo_dly_i, mi: mi_dly_i, cap: cap_off_e'(cap_off_i)};

  spi_skew_auto #(.RATE_W(RATE_W), .DIV_W(DIV_W)) i_auto (
    .rate_i (rate_i),
    .div_i  (div_i),
    .cfg_o  (auto_cfg)
  );

  spi_skew_cfg i_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .burst_start_i (burst_start_i),
    .auto_en_i     (auto_en_i),
    .man_cfg_i     (man_cfg),
    .auto_cfg_i    (auto_cfg),
    .cfg_o         (cfg_q)
  );

  spi_skew_line #(.DEPTH(DLY_MAX)) i_mosi_line (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (mosi_i), .sel_i (cfg_q.mo), .q_o (mosi_o)
  );

  assign miso_sel = MISO_SEL_W'(cfg_q.mi) + MISO_SEL_W'(MISO_BASE);

  spi_skew_line #(.DEPTH(MISO_DEPTH)) i_miso_line (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (miso_i), .sel_i (miso_sel), .q_o (miso_o)
  );

  // early capture is realised by delaying the strobe less than the data
  spi_skew_line #(.DEPTH(DLY_MAX)) i_cap_line (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (strobe_i), .sel_i (cfg_q.cap), .q_o (cap_o)
  );
endmodule

// File: rtl/spi_io_skew_chk.sv
module spi_io_skew_chk #(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              burst_start_i,
  input logic              auto_en_i,
  input logic [1:0]        mo_dly_i,
  input logic [1:0]        mi_dly_i,
  input logic [1:0]        cap_off_i,
  input logic [RATE_W-1:0] rate_i,
  input logic [DIV_W-1:0]  div_i,
  input logic              mosi_i,
  input logic              miso_i,
  input logic              strobe_i,
  input logic              mosi_o,
  input logic              miso_o,
  input logic              cap_o,
  input logic [1:0]        cfg_mo,
  input logic [1:0]        cfg_mi,
  input logic [1:0]        cfg_cap
);
  logic [2:0] age_q;
  logic       settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign settled = (age_q >= 3'd6);

  assert_reset_cfg_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cfg_mo == 2'd0 && cfg_mi == 2'd0 && cfg_cap == 2'd2));

  assert_mosi_dly_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && cfg_mo == 2'd2) |-> (mosi_o == $past(mosi_i, 2)));

  assert_miso_dly_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && cfg_mi == 2'd0) |-> (miso_o == $past(miso_i, 2)));

  assert_cap_late_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && cfg_cap == 2'd3) |-> (cap_o == $past(strobe_i, 3)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_start_i |=> $stable({cfg_mo, cfg_mi, cfg_cap}));

  assert_manual_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_i && !auto_en_i) |=>
      ({cfg_mo, cfg_mi, cfg_cap} == $past({mo_dly_i, mi_dly_i, cap_off_i})));

  assert_auto_fast_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_i && auto_en_i && rate_i >= RATE_W'(100)) |=>
      (cfg_cap == 2'd3 && cfg_mi == 2'd0));

  assert_auto_slow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_i && auto_en_i && rate_i < RATE_W'(40) && div_i >= DIV_W'(16)) |=>
      (cfg_mi == 2'd3 && cfg_cap == 2'd0));

  assert_auto_mo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_i && auto_en_i) |=> (cfg_mo == 2'd0));
endmodule

bind spi_io_skew spi_io_skew_chk #(.RATE_W(RATE_W), .DIV_W(DIV_W)) i_spi_io_skew_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_start_i (burst_start_i),
  .auto_en_i     (auto_en_i),
  .mo_dly_i      (mo_dly_i),
  .mi_dly_i      (mi_dly_i),
  .cap_off_i     (cap_off_i),
  .rate_i        (rate_i),
  .div_i         (div_i),
  .mosi_i        (mosi_i),
  .miso_i        (miso_i),
  .strobe_i      (strobe_i),
  .mosi_o        (mosi_o),
  .miso_o        (miso_o),
  .cap_o         (cap_o),
  .cfg_mo        (cfg_q.mo),
  .cfg_mi        (cfg_q.mi),
  .cfg_cap       (cfg_q.cap)
);

// File: tb/test_spi_io_skew.sv
module test_spi_io_skew;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       burst_start_i = 1'b0, auto_en_i = 1'b0;
  logic [1:0] mo_dly_i = '0, mi_dly_i = '0, cap_off_i = '0;
  logic [7:0] rate_i = '0, div_i = '0;
  logic       mosi_i = 1'b0, miso_i = 1'b0, strobe_i = 1'b0;
  logic       mosi_o, miso_o, cap_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [5:0] h_mo = '0, h_mi = '0, h_st = '0;  // bit k = input k cycles ago
  int e_mo = 0, e_mi = 0, e_cap = 2;
  string e_tag = "R1";

  always #10 clk_i = ~clk_i;  // 50 MHz

  spi_io_skew i_spi_io_skew (.*);

  function automatic void auto_exp(input int rate, input int dv,
                                   output int mi, output int cap, output string tag);
    mi = 0; cap = 0; tag = "R8";
    if (rate >= 100)     begin cap = 3; tag = "R7"; end
    else if (rate >= 80) begin cap = 2; tag = "R7"; end
    else if (rate >= 40) begin cap = 1; tag = "R7"; end
    else if (dv >= 16)   mi = 3;
    else if (dv >= 8)    mi = 2;
    else if (dv >= 6)    mi = 1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit bs, input bit au, input int mo, input int mi,
                      input int cap, input int rate, input int dv, input string hold_tag);
    @(negedge clk_i);
    burst_start_i = bs; auto_en_i = au;
    mo_dly_i = 2'(mo); mi_dly_i = 2'(mi); cap_off_i = 2'(cap);
    rate_i = 8'(rate); div_i = 8'(dv);
    mosi_i = 1'($urandom); miso_i = 1'($urandom); strobe_i = 1'($urandom);
    h_mo = {h_mo[4:0], mosi_i}; h_mi = {h_mi[4:0], miso_i}; h_st = {h_st[4:0], strobe_i};
    #5;
    check({"R2 mosi/", e_tag, hold_tag}, mosi_o, h_mo[e_mo]);
    check({"R3 miso/", e_tag, hold_tag}, miso_o, h_mi[e_mi + 2]);
    check({"R4 cap/",  e_tag, hold_tag}, cap_o,  h_st[e_cap]);
    if (bs) begin
      if (au) begin
        e_mo = 0;  // R9
        auto_exp(rate, dv, e_mi, e_cap, e_tag);
        e_tag = {e_tag, "+R9"};
      end else begin
        e_mo = mo; e_mi = mi; e_cap = cap; e_tag = "R6";
      end
    end
  endtask

  task automatic run_burst(input bit au, input int mo, input int mi, input int cap,
                           input int rate, input int dv, input int len);
    step(1'b1, au, mo, mi, cap, rate, dv, "");
    for (int i = 0; i < len; i++)
      step(1'b0, 1'($urandom), int'($urandom_range(3)), int'($urandom_range(3)),
           int'($urandom_range(3)), int'($urandom_range(150)), int'($urandom_range(40)), "/R5");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    #5;
    check("R1 reset mosi", mosi_o, 1'b0);
    check("R1 reset miso", miso_o, 1'b0);
    check("R1 reset cap",  cap_o,  1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: nominal settings straight after reset, no burst start
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3, 3, 0, 0, 0, "/R5");

    // directed manual corners: all-zero and all-max taps
    run_burst(1'b0, 0, 0, 0, 0, 0, 10);
    run_burst(1'b0, 3, 3, 3, 0, 0, 10);
    run_burst(1'b0, 1, 1, 1, 0, 0, 10);
    run_burst(1'b0, 2, 2, 2, 0, 0, 10);

    // R7 rate boundaries
    run_burst(1'b1, 3, 3, 0, 100, 20, 8);
    run_burst(1'b1, 3, 3, 0, 99, 20, 8);
    run_burst(1'b1, 3, 3, 0, 80, 20, 8);
    run_burst(1'b1, 3, 3, 0, 79, 20, 8);
    run_burst(1'b1, 3, 3, 0, 40, 20, 8);
    run_burst(1'b1, 3, 3, 3, 39, 20, 8);
    // R8 divisor boundaries
    run_burst(1'b1, 3, 0, 3, 10, 16, 8);
    run_burst(1'b1, 3, 0, 3, 10, 15, 8);
    run_burst(1'b1, 3, 0, 3, 10, 8, 8);
    run_burst(1'b1, 3, 0, 3, 10, 7, 8);
    run_burst(1'b1, 3, 0, 3, 10, 6, 8);
    run_burst(1'b1, 3, 3, 3, 10, 5, 8);

    // back-to-back burst starts
    for (int i = 0; i < 20; i++)
      step(1'b1, 1'($urandom), int'($urandom_range(3)), int'($urandom_range(3)),
           int'($urandom_range(3)), int'($urandom_range(150)), int'($urandom_range(40)), "");

    // constrained random
    for (int i = 0; i < 1500; i++)
      step(($urandom_range(7) == 0), 1'($urandom), int'($urandom_range(3)),
           int'($urandom_range(3)), int'($urandom_range(3)),
           int'($urandom_range(150)), int'($urandom_range(2, 40)), "/R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule